// File: doc/BRIEF.md
# One-Cycle Boost PFC Duty Controller

This block decides, once per switching period, how long the boost switch of a power-factor-correction rectifier stays on. It works from two signed 8-bit samples: the inductor current and the output voltage. The input line voltage is never measured. The control law sets vo·(1−d)·G = iL, so the line voltage is implied by the output voltage and the off-time fraction. The off-time fraction is therefore 1−d = K·iL/(G·vo). The block takes the current sample from the previous switching period as the average current for the present one.

The factor G is an emulated input admittance. A slow proportional-integral output-voltage loop produces it. The loop is updated only on every DECIM-th period, which keeps its bandwidth well under twice the line frequency. A restoring divider spends a fixed number of clock cycles on each quotient, well inside one switching period. The result is saturated and presented to a separate PWM generator together with a one-cycle strobe.

A warning flag reports when the admittance falls below the continuous-conduction range. That condition points to mixed or discontinuous conduction.

Top module: `pfc_duty_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, the next state is: duty_cmd = 0, duty_vld = 0, gin = GIN_INIT (600), cond_warn = 0, and both held samples = 0.
- R2: The duty produced for a period is 1023 − min(1023, floor(iL·2^18 / (G·vo))). Here iL and vo are the held samples at the period_start edge, and G is the gin value before that edge's loop update. Samples are two's complement, bit 7 being the sign.
- R3: When the quotient exceeds 1023, duty_cmd saturates to 0. This includes a zero or negative voltage sample, which is treated as 0 and gives a zero denominator.
- R4: A negative current sample is treated as zero current, giving duty_cmd = 1023.
- R5: With G and vo unchanged, a larger current sample gives a smaller duty_cmd than a smaller one.
- R6: A period_start edge uses the samples captured by the latest smp_valid before that edge. A sample that arrives on the same edge is used from the next period on.
- R7: duty_cmd and the one-cycle duty_vld strobe update at the 26th rising edge after the edge that samples period_start (NUM_W+1 edges, with NUM_W = 25). duty_cmd holds its value at every other edge.
- R8: gin and cond_warn change only on every 4th period_start edge after reset (DECIM = 4).
- R9: On an update edge, with e = 102 − vo (vo signed), the integrator I becomes clamp(I + 1·e) and gin becomes clamp(I_new + 4·e).
- R10: Both the integrator and gin are clamped to the range 0 to 1023.
- R11: cond_warn is 1 exactly when the updated gin is below 500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: capture il_smp and vo_smp |
| il_smp | input | 8 | Inductor current sample, two's complement |
| vo_smp | input | 8 | Output voltage sample, two's complement |
| period_start | input | 1 | One-cycle pulse at the start of each switching period |
| duty_cmd | output | 10 | Duty command, full scale 1023 |
| duty_vld | output | 1 | One-cycle strobe marking a new duty_cmd |
| gin | output | 10 | Present emulated input admittance |
| cond_warn | output | 1 | Admittance below the continuous-conduction range |

## Verification
The checker assumes two things about the inputs. First, successive period_start pulses are at least 27 cycles apart, so a running division is never restarted. Second, reset is held for at least one edge. The latency and hold properties rely on both. The bench meets them by issuing each period_start only after it has seen the previous duty_vld. It drives smp_valid and period_start as single-cycle pulses away from the clock edge, including one case where both are given on the same edge. It steers gin to both clamp limits with long runs of extreme voltage samples.

// File: rtl/pfc_pkg.sv
// Package: shared types of the one-cycle PFC duty controller.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package pfc_pkg;

    // Divider sequencing state
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    // Nominal admittance after reset and its conduction-warning threshold
    localparam int GIN_INIT_DEF = 600;
    localparam int WARN_TH_DEF  = 500;

endpackage

// File: rtl/pfc_sample_hold.sv
// Module: pfc_sample_hold
// Holds the latest current and voltage samples on every smp_valid strobe.
// Provides clamped magnitudes for the divider and the raw voltage code for the loop.
// Assumes the samples are two's complement, with the sign in the top bit.
module pfc_sample_hold #(
    parameter int DATA_W = 8,
    localparam int MAG_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] il_in,
    input  logic [DATA_W-1:0] vo_in,
    output logic [MAG_W-1:0]  il_mag,
    output logic [MAG_W-1:0]  vo_mag,
    output logic [DATA_W-1:0] vo_raw
);

    logic [DATA_W-1:0] il_hold;
    logic [DATA_W-1:0] vo_hold;

    // Capture both samples together on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            il_hold <= '0;
            vo_hold <= '0;
        end else if (smp_valid) begin
            il_hold <= il_in;
            vo_hold <= vo_in;
        end
    end

    // Negative codes count as zero magnitude
    always_comb begin
        il_mag = il_hold[DATA_W-1] ? '0 : il_hold[MAG_W-1:0];
        vo_mag = vo_hold[DATA_W-1] ? '0 : vo_hold[MAG_W-1:0];
        vo_raw = vo_hold;
    end

endmodule

// File: rtl/pfc_seq_div.sv
// Module: pfc_seq_div
// Restoring divider that produces one quotient bit per clock.
// A start pulse loads the operands. done pulses NUM_W edges later, with quo valid.
// Assumes start does not recur while a division runs; a new start restarts it.
// A zero divisor gives an all-ones quotient.
module pfc_seq_div
    import pfc_pkg::*;
#(
    parameter int NUM_W = 25,
    parameter int DEN_W = 17,
    localparam int CNT_W = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             done
);

    div_state_e       state;
    logic [CNT_W-1:0] bit_cnt;
    logic [NUM_W-1:0] q_sh;
    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_r;
    logic [DEN_W:0]   trial;
    logic             fits;
    logic [DEN_W:0]   diff;

    // Shift the next dividend bit into the partial remainder and trial-subtract
    always_comb begin
        trial = {rem, q_sh[NUM_W-1]};
        fits  = (trial >= {1'b0, den_r});
        diff  = trial - {1'b0, den_r};
    end

    // Load on start, then one restoring step per edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= DIV_IDLE;
            bit_cnt <= '0;
            q_sh    <= '0;
            rem     <= '0;
            den_r   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state   <= DIV_RUN;
                bit_cnt <= CNT_W'(NUM_W);
                q_sh    <= num;
                rem     <= '0;
                den_r   <= den;
            end else if (state == DIV_RUN) begin
                rem     <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                q_sh    <= {q_sh[NUM_W-2:0], fits};
                bit_cnt <= bit_cnt - 1'b1;
                if (bit_cnt == CNT_W'(1)) begin
                    state <= DIV_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quo = q_sh;

endmodule

// File: rtl/pfc_volt_pi.sv
// Module: pfc_volt_pi
// Decimated proportional-integral voltage loop that produces the emulated admittance.
// Updates on every DECIM-th tick, using the held voltage code.
// The integrator and the output are both clamped to 0..2^GIN_W-1.
// Also raises a warning when the result drops below WARN_TH.
// Assumes tick is a single-cycle pulse per switching period.
module pfc_volt_pi
    import pfc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int GIN_W    = 10,
    parameter int DECIM    = 4,
    parameter int VREF     = 102,
    parameter int KP       = 4,
    parameter int KI       = 1,
    parameter int GIN_INIT = GIN_INIT_DEF,
    parameter int WARN_TH  = WARN_TH_DEF,
    localparam int ACC_W   = GIN_W + DATA_W + 8,
    localparam int DCW     = (DECIM > 1) ? $clog2(DECIM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DATA_W-1:0] vo_raw,
    output logic [GIN_W-1:0]  gin,
    output logic              warn
);

    localparam logic signed [ACC_W-1:0] VREF_S = ACC_W'(VREF);
    localparam logic signed [ACC_W-1:0] KP_S   = ACC_W'(KP);
    localparam logic signed [ACC_W-1:0] KI_S   = ACC_W'(KI);
    localparam logic signed [ACC_W-1:0] GMAX_S = ACC_W'((1 << GIN_W) - 1);

    logic [DCW-1:0]          dec_cnt;
    logic                    upd;
    logic [GIN_W-1:0]        integ;
    logic signed [ACC_W-1:0] err;
    logic signed [ACC_W-1:0] i_sum;
    logic signed [ACC_W-1:0] g_sum;
    logic [GIN_W-1:0]        i_next;
    logic [GIN_W-1:0]        g_next;

    // Error, integrator step and proportional sum, each limited to the legal range
    always_comb begin
        err   = VREF_S - ACC_W'($signed(vo_raw));
        i_sum = $signed({{(ACC_W-GIN_W){1'b0}}, integ}) + err * KI_S;
        if (i_sum < 0)           i_next = '0;
        else if (i_sum > GMAX_S) i_next = GMAX_S[GIN_W-1:0];
        else                     i_next = i_sum[GIN_W-1:0];
        g_sum = $signed({{(ACC_W-GIN_W){1'b0}}, i_next}) + err * KP_S;
        if (g_sum < 0)           g_next = '0;
        else if (g_sum > GMAX_S) g_next = GMAX_S[GIN_W-1:0];
        else                     g_next = g_sum[GIN_W-1:0];
    end

    assign upd = tick && (dec_cnt == DCW'(DECIM - 1));

    // Count ticks and update the loop state on the decimated one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_cnt <= '0;
            integ   <= GIN_W'(GIN_INIT);
            gin     <= GIN_W'(GIN_INIT);
            warn    <= (GIN_INIT < WARN_TH);
        end else if (tick) begin
            dec_cnt <= upd ? '0 : dec_cnt + 1'b1;
            if (upd) begin
                integ <= i_next;
                gin   <= g_next;
                warn  <= (g_next < GIN_W'(WARN_TH));
            end
        end
    end

endmodule

// File: rtl/pfc_duty_ctrl.sv
// Module: pfc_duty_ctrl (top)
// One-cycle PFC duty controller.
// On each period_start it divides the scaled current by admittance times voltage,
// which gives the off-time fraction, then saturates and complements it into a duty command.
// Assumes period_start pulses are spaced longer than the divider latency (NUM_W + 2 cycles).
module pfc_duty_ctrl
    import pfc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DUTY_W   = 10,
    parameter int GIN_W    = 10,
    parameter int K_SH     = 18,
    parameter int DECIM    = 4,
    parameter int VREF     = 102,
    parameter int KP       = 4,
    parameter int KI       = 1,
    parameter int GIN_INIT = GIN_INIT_DEF,
    parameter int WARN_TH  = WARN_TH_DEF,
    localparam int MAG_W   = DATA_W - 1,
    localparam int NUM_W   = MAG_W + K_SH,
    localparam int DEN_W   = GIN_W + MAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] il_smp,
    input  logic [DATA_W-1:0] vo_smp,
    input  logic              period_start,
    output logic [DUTY_W-1:0] duty_cmd,
    output logic              duty_vld,
    output logic [GIN_W-1:0]  gin,
    output logic              cond_warn
);

    localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

    logic [MAG_W-1:0]  il_mag;
    logic [MAG_W-1:0]  vo_mag;
    logic [DATA_W-1:0] vo_raw;
    logic [NUM_W-1:0]  num;
    logic [DEN_W-1:0]  den;
    logic [NUM_W-1:0]  quo;
    logic              div_done;
    logic              q_over;
    logic [DUTY_W-1:0] q_low;
    logic [DUTY_W-1:0] duty_next;

    pfc_sample_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .il_in     (il_smp),
        .vo_in     (vo_smp),
        .il_mag    (il_mag),
        .vo_mag    (vo_mag),
        .vo_raw    (vo_raw)
    );

    pfc_volt_pi #(
        .DATA_W   (DATA_W),
        .GIN_W    (GIN_W),
        .DECIM    (DECIM),
        .VREF     (VREF),
        .KP       (KP),
        .KI       (KI),
        .GIN_INIT (GIN_INIT),
        .WARN_TH  (WARN_TH)
    ) u_pi (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (period_start),
        .vo_raw (vo_raw),
        .gin    (gin),
        .warn   (cond_warn)
    );

    // Operands: current scaled by 2^K_SH over admittance times voltage
    assign num = {il_mag, {K_SH{1'b0}}};
    assign den = DEN_W'(gin) * DEN_W'(vo_mag);

    pfc_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (period_start),
        .num   (num),
        .den   (den),
        .quo   (quo),
        .done  (div_done)
    );

    // Overflow detection of the quotient, present only when it is wider than the duty
    generate
        if (NUM_W > DUTY_W) begin : g_wide
            assign q_over = |quo[NUM_W-1:DUTY_W];
            assign q_low  = quo[DUTY_W-1:0];
        end else begin : g_narrow
            assign q_over = 1'b0;
            assign q_low  = DUTY_W'(quo);
        end
    endgenerate

    // Saturate the off-time fraction and complement it into the on-time
    assign duty_next = DUTY_MAX - (q_over ? DUTY_MAX : q_low);

    // Register the new command with its strobe when the divider finishes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_cmd <= '0;
            duty_vld <= 1'b0;
        end else begin
            duty_vld <= div_done;
            if (div_done) duty_cmd <= duty_next;
        end
    end

endmodule

// File: rtl/pfc_duty_ctrl_chk.sv
// Module: pfc_duty_ctrl_chk
// Temporal checks of the duty controller, observed at its ports.
// Assumes period_start pulses are spaced by more than NUM_W + 2 cycles.
module pfc_duty_ctrl_chk #(
    parameter int DUTY_W   = 10,
    parameter int GIN_W    = 10,
    parameter int NUM_W    = 25,
    parameter int DECIM    = 4,
    parameter int GIN_INIT = 600,
    parameter int WARN_TH  = 500
) (
    input logic              clk,
    input logic              rst_n,
    input logic              period_start,
    input logic [DUTY_W-1:0] duty_cmd,
    input logic              duty_vld,
    input logic [GIN_W-1:0]  gin,
    input logic              cond_warn
);

    logic [15:0] lat_cnt;
    logic        seen_start;
    int unsigned per_cnt;

    // Edges since the latest period_start, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt    <= '0;
            seen_start <= 1'b0;
        end else if (period_start) begin
            lat_cnt    <= '0;
            seen_start <= 1'b1;
        end else if (lat_cnt != 16'hFFFF) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    // Position of each period within the decimation group
    always_ff @(posedge clk) begin
        if (!rst_n)             per_cnt <= 0;
        else if (period_start)  per_cnt <= (per_cnt == DECIM - 1) ? 0 : per_cnt + 1;
    end

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (duty_cmd == '0 && !duty_vld && gin == GIN_W'(GIN_INIT) && !cond_warn));

    // R7: strobe arrives a fixed number of edges after period_start
    a_r7_vld_latency: assert property (@(posedge clk) disable iff (!rst_n)
        duty_vld |-> (seen_start && lat_cnt == 16'(NUM_W + 1)));

    // R7: strobe lasts one cycle
    a_r7_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        duty_vld |=> !duty_vld);

    // R7: command holds between strobes
    a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !duty_vld |-> $stable(duty_cmd));

    // R8: admittance moves only on a decimated period edge
    a_r8_gin_decim: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gin) |-> $past(period_start && per_cnt == DECIM - 1));

    // R11: warning follows the admittance threshold
    a_r11_warn_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        cond_warn == (gin < GIN_W'(WARN_TH)));

endmodule

bind pfc_duty_ctrl pfc_duty_ctrl_chk #(
    .DUTY_W   (DUTY_W),
    .GIN_W    (GIN_W),
    .NUM_W    (NUM_W),
    .DECIM    (DECIM),
    .GIN_INIT (GIN_INIT),
    .WARN_TH  (WARN_TH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .duty_cmd     (duty_cmd),
    .duty_vld     (duty_vld),
    .gin          (gin),
    .cond_warn    (cond_warn)
);

// File: tb/pfc_duty_ctrl_bench.sv
// Bench: pfc_duty_ctrl_bench
// Walks a stimulus table, then runs directed cases for reset, sample timing and clamping.
module pfc_duty_ctrl_bench;

    localparam int DATA_W = 8, DUTY_W = 10, GIN_W = 10, K_SH = 18, DECIM = 4;
    localparam int VREF = 102, KP = 4, KI = 1, GIN_INIT = 600, WARN_TH = 500;
    localparam int NUM_W = DATA_W - 1 + K_SH;
    localparam int FS = 1023;
    localparam int VEC_N = 12;
    localparam int VEC_IL [VEC_N] = '{100, 50, 127, 0, -20, 100, 100, 80, 80, 127, 10, 60};
    localparam int VEC_VO [VEC_N] = '{102, 102, 102, 102, 102, 0, -50, 90, 110, 20, 127, 102};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic period_start = 1'b0;
    logic [DATA_W-1:0] il_smp = '0;
    logic [DATA_W-1:0] vo_smp = '0;
    logic [DUTY_W-1:0] duty_cmd;
    logic duty_vld;
    logic [GIN_W-1:0] gin;
    logic cond_warn;

    int checks = 0;
    int fails = 0;
    int h_il = 0, h_vo = 0, m_integ = GIN_INIT, m_gin = GIN_INIT, m_pcnt = 0;

    pfc_duty_ctrl #(
        .DATA_W(DATA_W), .DUTY_W(DUTY_W), .GIN_W(GIN_W), .K_SH(K_SH), .DECIM(DECIM),
        .VREF(VREF), .KP(KP), .KI(KI), .GIN_INIT(GIN_INIT), .WARN_TH(WARN_TH)
    ) u_pfc_duty_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .il_smp(il_smp), .vo_smp(vo_smp),
        .period_start(period_start), .duty_cmd(duty_cmd), .duty_vld(duty_vld),
        .gin(gin), .cond_warn(cond_warn)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int f_duty(input int il, input int vo, input int g);
        longint n, d, q;
        n = longint'(il < 0 ? 0 : il) <<< K_SH;
        d = longint'(g) * longint'(vo < 0 ? 0 : vo);
        q = (d == 0) ? FS : n / d;
        if (q > FS) q = FS;
        return FS - int'(q);
    endfunction

    function automatic int f_clamp(input int v);
        return (v < 0) ? 0 : ((v > FS) ? FS : v);
    endfunction

    task automatic model_pi();
        int e;
        m_pcnt++;
        if (m_pcnt == DECIM) begin
            m_pcnt  = 0;
            e       = VREF - h_vo;
            m_integ = f_clamp(m_integ + KI * e);
            m_gin   = f_clamp(m_integ + KP * e);
        end
    endtask

    // One switching period: sample strobe (before or on the period edge), then wait for the strobe
    task automatic do_period(input int il, input int vo, input bit same, input string tag,
                             output int duty_seen);
        int exp_d;
        int cyc;
        if (!same) begin
            @(negedge clk);
            il_smp = DATA_W'(il); vo_smp = DATA_W'(vo); smp_valid = 1'b1;
            h_il = il; h_vo = vo;
            @(negedge clk);
            smp_valid = 1'b0; period_start = 1'b1;
        end else begin
            @(negedge clk);
            il_smp = DATA_W'(il); vo_smp = DATA_W'(vo); smp_valid = 1'b1; period_start = 1'b1;
        end
        exp_d = f_duty(h_il, h_vo, m_gin);
        @(negedge clk);
        period_start = 1'b0; smp_valid = 1'b0;
        cyc = 1;
        while (!duty_vld && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk("R7 strobe latency", cyc, NUM_W + 2);
        chk(tag, duty_cmd, exp_d);
        model_pi();
        chk("R9 admittance", gin, m_gin);
        chk("R11 warning", cond_warn, (m_gin < WARN_TH) ? 1 : 0);
        if (same) begin h_il = il; h_vo = vo; end
        duty_seen = duty_cmd;
    endtask

    task automatic model_reset();
        h_il = 0; h_vo = 0; m_integ = GIN_INIT; m_gin = GIN_INIT; m_pcnt = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int d1, d2, dd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset
        chk("R1 duty after reset", duty_cmd, 0);
        chk("R1 strobe after reset", duty_vld, 0);
        chk("R1 admittance after reset", gin, GIN_INIT);
        chk("R1 warning after reset", cond_warn, 0);

        // R5 and R8: same admittance across the first periods of a group
        do_period(100, 102, 0, "R2 nominal", d1);
        do_period(50, 102, 0, "R2 half current", d2);
        chk("R5 smaller current gives larger duty", (d2 > d1) ? 1 : 0, 1);
        do_period(80, 0, 0, "R3 zero voltage saturates", dd);
        chk("R3 zero voltage duty", dd, 0);
        chk("R8 admittance held before 4th period", gin, GIN_INIT);
        do_period(80, 50, 0, "R2 on update period", dd);

        // R7: command holds after the strobe
        repeat (5) @(negedge clk);
        chk("R7 command held", duty_cmd, dd);
        chk("R7 strobe low", duty_vld, 0);

        // Table walk
        for (int i = 0; i < VEC_N; i++) begin
            do_period(VEC_IL[i], VEC_VO[i], 0, "R2 table vector", dd);
            if (VEC_IL[i] < 0) chk("R4 negative current gives full duty", dd, FS);
        end

        // R6: a sample given on the period edge waits one period
        do_period(30, 102, 0, "R6 prior sample", dd);
        do_period(120, 102, 1, "R6 same-edge sample not yet used", dd);
        do_period(5, 102, 1, "R6 previous sample now used", dd);

        // R10: drive the integrator to the upper limit
        for (int i = 0; i < 16; i++) do_period(50, -128, 0, "R3 negative voltage", dd);
        chk("R10 upper clamp", gin, FS);
        chk("R11 no warning at top", cond_warn, 0);

        // R10 and R11: drive it to the lower limit
        for (int i = 0; i < 200; i++) do_period(60, 127, 0, "R2 high voltage run", dd);
        chk("R10 lower clamp", gin, 0);
        chk("R11 warning at low admittance", cond_warn, 1);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 duty on reset", duty_cmd, 0);
        chk("R1 admittance on reset", gin, GIN_INIT);
        chk("R1 warning on reset", cond_warn, 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        do_period(100, 102, 0, "R2 after reset", dd);
        chk("R2 after reset value", dd, 595);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule